// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from sixteen on-chip peripheral sources and elects a single winner. Software gives each source a 4-bit priority through a small register bus. A level of zero disables the source. Among the asserted sources with a non-zero level, the highest level wins. When several candidates hold the same level, the source with the lowest index wins. The winner is forwarded to the CPU only if its level is strictly above the CPU's current mask level and the global block input is low.

The election is combinational and is registered once, so the request output and its level follow the inputs with one cycle of latency. The CPU takes an interrupt by pulsing an acknowledge. At that edge the block stores an event code for the winner that is eligible in that same cycle. The code is a base value plus a fixed stride times the source index. All sources share one handler, and that handler reads the code and branches on it. If the request has gone away by the time of the acknowledge, the stored code is zero and the handler can simply return.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Four 16-bit priority registers sit at bus addresses 0 to 3. Bits [4n+3:4n] of the register at address k hold the level of source 4k+n. Each register reads back what was last written to it.
- R2: After reset, every priority level is 0, the event code register reads 0, and the request output and level output are both low.
- R3: A source whose level is 0 never wins, whatever its request input does.
- R4: One cycle after the inputs are applied, the request output is high exactly when the highest level among asserted sources is strictly greater than the mask input. The level output then carries that level, and it is 0 whenever the request output is low.
- R5: Among asserted sources that share the highest level, the one with the lowest index wins.
- R6: While the block input is 1, the request output is low in the following cycle, and an acknowledge leaves the event code register unchanged.
- R7: An acknowledge with the block input at 0 loads the event code register with 0x200 + 0x20 × index of the source eligible in that same cycle. The register reads at address 4 in bits [11:0], with bits [15:12] reading 0. It holds its value until the next such acknowledge.
- R8: If no source is eligible at the acknowledge edge, the event code register is loaded with 0.
- R9: Addresses 5 to 7 read 0. Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 16 | Level request per peripheral source |
| blk | input | 1 | Global block; 1 suppresses acceptance |
| cpu_mask | input | 4 | CPU's current interrupt mask level |
| irq_ack | input | 1 | CPU acceptance pulse |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 3 | Register bus word address |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data (combinational, 0 when not selected) |
| irq_req | output | 1 | Registered interrupt request to the CPU |
| irq_lvl | output | 4 | Level of the forwarded request |

## Verification
Acknowledge capture and request withdrawal can fall in the same cycle. The bench first lets a source raise the request. Then, in the acknowledge cycle, it drops the source or raises the mask, so the registered request is still high while the live election is empty. It expects a zero code. The bench also acknowledges in the same cycle as a change to the request pattern or the mask. It judges the stored code against the winner that its own model computes for the inputs of that cycle, not against the level the request output shows.

// File: rtl/pic_pkg.sv
// Shared sizes and types for the programmable priority interrupt controller.
// Assumes the source count is a multiple of the fields per register.
package pic_pkg;
    localparam int SRC_N    = 16;
    localparam int LVL_W    = 4;
    localparam int REG_W    = 16;
    localparam int FLD_N    = REG_W / LVL_W;
    localparam int PREG_N   = SRC_N / FLD_N;
    localparam int IDX_W    = $clog2(SRC_N);
    localparam int CODE_W   = 12;
    localparam int ADDR_W   = 3;
    localparam int PRIO_W   = SRC_N * LVL_W;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
        lvl_t lvl;
    } win_t;
endpackage

// File: rtl/pic_prio_regs.sv
// Priority register file and read mux.
// Holds PREG_N registers of FLD_N level fields each, and exposes them flattened
// by source. The event code arrives from the acceptance stage and is read-only.
// Assumes that single-cycle write strobes qualify bus_sel.
module pic_prio_regs
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  code_t               evt_code,
    output logic [PRIO_W-1:0]   prio_flat,
    output logic [REG_W-1:0]    bus_rdata
);
    localparam int CODE_ADDR = PREG_N;

    logic [REG_W-1:0] preg_q [PREG_N];

    genvar k;
    generate
        for (k = 0; k < PREG_N; k++) begin : g_preg
            // Write one priority register when its address is hit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    preg_q[k] <= '0;
                else if (bus_sel && bus_wr && (bus_addr == ADDR_W'(k)))
                    preg_q[k] <= bus_wdata;
            end
            assign prio_flat[k*REG_W +: REG_W] = preg_q[k];
        end
    endgenerate

    // Select read data by address; unused addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            for (int i = 0; i < PREG_N; i++)
                if (bus_addr == ADDR_W'(i))
                    bus_rdata = preg_q[i];
            if (bus_addr == ADDR_W'(CODE_ADDR))
                bus_rdata = REG_W'(evt_code);
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
// Combinational election across all sources.
// A source takes part when it is requesting and its level is non-zero. The
// highest level wins, and the lower index wins a tie. Works for any SRC_N.
module pic_arbiter
    import pic_pkg::*;
(
    input  logic [SRC_N-1:0]   req,
    input  logic [PRIO_W-1:0]  prio_flat,
    output win_t               win
);
    lvl_t eff_lvl [SRC_N];

    genvar s;
    generate
        for (s = 0; s < SRC_N; s++) begin : g_eff
            assign eff_lvl[s] = req[s] ? prio_flat[s*LVL_W +: LVL_W] : '0;
        end
    endgenerate

    // Scan from the highest index down so lower indices overwrite on equal levels.
    always_comb begin
        win = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if ((eff_lvl[i] != '0) && (eff_lvl[i] >= win.lvl)) begin
                win.valid = 1'b1;
                win.idx   = idx_t'(i);
                win.lvl   = eff_lvl[i];
            end
        end
    end
endmodule

// File: rtl/pic_accept.sv
// Masking, request register and event code capture.
// The elected winner is compared with the CPU mask and gated by the block
// input, then registered towards the CPU. On an acknowledge that is not
// blocked, the code of the winner live in that cycle (or zero) is stored.
module pic_accept
    import pic_pkg::*;
#(
    parameter code_t CODE_BASE = 12'h200,
    parameter code_t CODE_STEP = 12'h020
) (
    input  logic   clk,
    input  logic   rst_n,
    input  win_t   win,
    input  lvl_t   cpu_mask,
    input  logic   blk,
    input  logic   irq_ack,
    output logic   irq_req,
    output lvl_t   irq_lvl,
    output code_t  evt_code
);
    logic  above_mask;
    logic  eligible;
    code_t live_code;

    // Decide whether the current winner may be forwarded and compute its code.
    always_comb begin
        above_mask = win.valid && (win.lvl > cpu_mask);
        eligible   = above_mask && !blk;
        live_code  = CODE_BASE + code_t'(win.idx) * CODE_STEP;
    end

    // Register the request and its level towards the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_lvl <= '0;
        end else begin
            irq_req <= eligible;
            irq_lvl <= eligible ? win.lvl : '0;
        end
    end

    // Capture the event code on an acknowledge that is not blocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_code <= '0;
        else if (irq_ack && !blk)
            evt_code <= above_mask ? live_code : '0;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the programmable priority interrupt controller.
// Connects the register file, the election and the acceptance stage.
// Assumes all inputs are synchronous to clk.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter code_t CODE_BASE = 12'h200,
    parameter code_t CODE_STEP = 12'h020
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_N-1:0]    irq_src,
    input  logic                blk,
    input  logic [LVL_W-1:0]    cpu_mask,
    input  logic                irq_ack,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                irq_req,
    output logic [LVL_W-1:0]    irq_lvl
);
    logic [PRIO_W-1:0] prio_flat;
    code_t             evt_code_q;
    win_t              win;

    pic_prio_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt_code  (evt_code_q),
        .prio_flat (prio_flat),
        .bus_rdata (bus_rdata)
    );

    pic_arbiter u_arb (
        .req       (irq_src),
        .prio_flat (prio_flat),
        .win       (win)
    );

    pic_accept #(
        .CODE_BASE (CODE_BASE),
        .CODE_STEP (CODE_STEP)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .cpu_mask  (cpu_mask),
        .blk       (blk),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .irq_lvl   (irq_lvl),
        .evt_code  (evt_code_q)
    );
endmodule

// File: rtl/pic_checker.sv
// Temporal checks on the controller, attached to the top through bind.
module pic_checker
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blk,
    input  logic [LVL_W-1:0]   cpu_mask,
    input  logic               irq_ack,
    input  logic               irq_req,
    input  logic [LVL_W-1:0]   irq_lvl,
    input  code_t              evt_code,
    input  logic [PRIO_W-1:0]  prio_flat
);
    // R2: the first cycle out of reset shows cleared levels and no request.
    p_reset_clear_r2: assert property (@(posedge clk)
        $rose(rst_n) |-> (prio_flat == '0 && !irq_req && evt_code == '0));

    // R3: a forwarded request never carries level zero.
    p_nonzero_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != '0));

    // R4: a forwarded level is above the mask of the previous cycle.
    p_above_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > $past(cpu_mask)));

    // R4: the level output is zero when no request is forwarded.
    p_idle_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_lvl == '0));

    // R6: a block in one cycle suppresses the request in the next.
    p_block_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blk) |-> !irq_req);

    // R7: without an unblocked acknowledge the event code holds.
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(irq_ack) && !$past(blk)) |-> $stable(evt_code));
endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk       (blk),
    .cpu_mask  (cpu_mask),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_lvl   (irq_lvl),
    .evt_code  (evt_code_q),
    .prio_flat (prio_flat)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_src = '0;
    logic        blk = 1'b0;
    logic [3:0]  cpu_mask = '0;
    logic        irq_ack = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_req;
    logic [3:0]  irq_lvl;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .blk(blk),
        .cpu_mask(cpu_mask), .irq_ack(irq_ack), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_lvl(irq_lvl)
    );

    always #10 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [3:0]  shp [16];
    logic [15:0] lf = 16'hACE1;
    int          m_idx;
    int          m_lvl;
    bit          m_ok;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (a < 4)
            for (int n = 0; n < 4; n++) shp[a*4+n] = d[n*4 +: 4];
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    function automatic logic [15:0] pack_reg(input int k);
        logic [15:0] r;
        for (int n = 0; n < 4; n++) r[n*4 +: 4] = shp[k*4+n];
        return r;
    endfunction

    // Model of election and masking from the requirements.
    task automatic model(input logic [15:0] s, input logic [3:0] m);
        m_idx = 0; m_lvl = 0;
        for (int i = 0; i < 16; i++)
            if (s[i] && shp[i] != 0 && int'(shp[i]) > m_lvl) begin
                m_lvl = shp[i]; m_idx = i;
            end
        m_ok = (m_lvl > int'(m));
    endtask

    // Apply inputs, then check request and level one cycle later (R4).
    task automatic apply(input string rq, input logic [15:0] s, input logic [3:0] m, input logic b);
        @(negedge clk);
        irq_src = s; cpu_mask = m; blk = b;
        model(s, m);
        @(negedge clk);
        chk({rq, " req"}, irq_req, (m_ok && !b));
        chk({rq, " lvl"}, irq_lvl, (m_ok && !b) ? m_lvl : 0);
    endtask

    // Acknowledge with given inputs in that cycle and check the stored code (R7, R8).
    task automatic ack_chk(input string rq, input logic [15:0] s, input logic [3:0] m);
        logic [15:0] d;
        @(negedge clk);
        irq_src = s; cpu_mask = m; blk = 0; irq_ack = 1;
        model(s, m);
        @(negedge clk);
        irq_ack = 0;
        rd(3'd4, d);
        chk({rq, " code"}, d, m_ok ? (16'h200 + 16'h20 * m_idx) : 16'h0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] held;
        for (int i = 0; i < 16; i++) shp[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state.
        chk("R2 req", irq_req, 0);
        chk("R2 lvl", irq_lvl, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R2 reg", d, 0);
        end

        // R1: write and read back each priority register.
        for (int k = 0; k < 4; k++) begin
            wr(3'(k), 16'h1234 + 16'h1111 * k[15:0]);
            rd(3'(k), d);
            chk("R1 readback", d, 16'h1234 + 16'h1111 * k[15:0]);
        end
        for (int k = 0; k < 4; k++) begin
            wr(3'(k), 16'h0);
        end

        // R3/R4/R7: each source alone at each level, mask 0.
        for (int i = 0; i < 16; i++) begin
            for (int l = 0; l < 16; l++) begin
                shp[i] = 4'(l);
                wr(3'(i / 4), pack_reg(i / 4));
                apply(l == 0 ? "R3 single" : "R4 single", 16'(1 << i), 4'd0, 1'b0);
                ack_chk(l == 0 ? "R8 single" : "R7 single", 16'(1 << i), 4'd0);
            end
            shp[i] = 0;
            wr(3'(i / 4), pack_reg(i / 4));
        end

        // R4: mask sweep on source 5.
        for (int l = 1; l < 16; l++) begin
            shp[5] = 4'(l);
            wr(3'd1, pack_reg(1));
            for (int m = 0; m < 16; m++)
                apply("R4 mask", 16'h0020, 4'(m), 1'b0);
        end

        // R5: every source at level 7, assorted request patterns.
        for (int k = 0; k < 4; k++) wr(3'(k), 16'h7777);
        for (int t = 0; t < 60; t++) begin
            step_lf();
            apply("R5 tie", lf, 4'd3, 1'b0);
            ack_chk("R5 tie", lf, 4'd3);
        end

        // R4/R5/R7: random levels, requests and masks.
        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < 4; k++) begin
                step_lf();
                wr(3'(k), lf);
            end
            for (int u = 0; u < 6; u++) begin
                step_lf();
                d = lf;
                step_lf();
                apply("R4 random", d, lf[3:0], 1'b0);
                step_lf();
                ack_chk("R7 random", lf, d[3:0]);
            end
        end

        // R6: block suppresses the request and an acknowledge under block.
        for (int k = 0; k < 4; k++) wr(3'(k), 16'h9999);
        ack_chk("R7 prep", 16'h0100, 4'd0);
        rd(3'd4, held);
        apply("R6 block", 16'hFFFF, 4'd0, 1'b1);
        @(negedge clk);
        irq_src = 16'h0001; irq_ack = 1; blk = 1;
        @(negedge clk);
        irq_ack = 0; blk = 0;
        rd(3'd4, d);
        chk("R6 ack blocked", d, held);
        apply("R6 unblock", 16'h0001, 4'd0, 1'b0);

        // R7: code holds without acknowledge while inputs change.
        ack_chk("R7 load", 16'h0400, 4'd2);
        rd(3'd4, held);
        apply("R7 other", 16'h8000, 4'd0, 1'b0);
        rd(3'd4, d);
        chk("R7 hold", d, held);

        // R8: request withdrawn in the acknowledge cycle.
        apply("R8 raise", 16'h0008, 4'd0, 1'b0);
        ack_chk("R8 withdraw", 16'h0000, 4'd0);
        apply("R8 raise2", 16'h0008, 4'd0, 1'b0);
        ack_chk("R8 masked", 16'h0008, 4'd9);

        // R9: writes to 4..7 ignored, 5..7 read zero.
        ack_chk("R9 prep", 16'h0002, 4'd0);
        rd(3'd4, held);
        for (int a = 4; a < 8; a++) wr(3'(a), 16'hFFFF);
        rd(3'd4, d);
        chk("R9 code kept", d, held);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d);
            chk("R9 unused", d, 0);
        end
        for (int k = 0; k < 4; k++) begin
            rd(3'(k), d);
            chk("R9 prio kept", d, 16'h9999);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule